// File: doc/BRIEF.md
# Ordered-Entry Combination Lock

This block is a small clocked state machine guarding a latch that releases only when a dial is turned to three values in a fixed order. Each dial action arrives as a one-cycle strobe carrying a turn direction and a dial reading. The combination is a right turn to 13, then a left turn to 22, then a right turn to 3. The same three values in any other order do not open the lock. A matching value turned the wrong way does not open it either.

The machine has four states, held in two bits and shown on a state port. A strobe that does not match the step the machine is waiting for sends it back to the start. There is one exception: if the wrong strobe is the first step of the combination, it counts as a fresh first step. Once the lock is open, any further strobe or a relock pulse closes it again. The outputs are Moore outputs, so every change appears one clock edge after the input that caused it.

Top module: `combo_lock`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising edge forces the idle state: `state_code` = 2'b00 and `unlocked` = 0 after that edge.
- R2: State codes on `state_code` are 2'b00 idle, 2'b01 first step done, 2'b10 first two steps done, and 2'b11 open.
- R3: From idle, the strobes right-13, left-22 and right-3 advance the state by one code per strobe and reach the open state. Direction encoding is `entry_dir` = 0 for right and 1 for left.
- R4: A cycle with `entry_valid` = 0 and `relock` = 0 leaves the state unchanged.
- R5: A strobe that does not match the expected step returns the machine to idle. If that strobe is right-13, the machine goes to state 2'b01 instead.
- R6: Direction is part of each step: a strobe with the correct value but the opposite direction counts as a wrong entry.
- R7: `unlocked` is 1 exactly when the state is 2'b11.
- R8: Any strobe received in the open state returns the machine to idle.
- R9: A `relock` pulse returns the machine to idle from any state, and takes priority over a strobe in the same cycle.
- R10: Entering the three combination values in an order other than 13, 22, 3 never reaches the open state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes occur on its rising edge |
| rst | input | 1 | Synchronous active-high reset to idle |
| entry_valid | input | 1 | One-cycle strobe marking a dial entry |
| entry_dir | input | 1 | Turn direction of the entry: 0 right, 1 left |
| entry_val | input | 5 | Dial value of the entry, 0 to 31 |
| relock | input | 1 | Pulse that closes the lock and restarts the sequence |
| unlocked | output | 1 | High while the lock is open |
| state_code | output | 2 | Current state code |

## Verification
The correct three-step sequence shows that matching entries advance the machine and open it. The same values in a scrambled order show that order matters, not just the set of values. A correct value turned the wrong way separates direction checking from value checking. A partial sequence broken by a fresh right-13 shows the restart-as-first-step rule apart from a plain reset to idle. Idle gaps between strobes, strobes made while open, and a relock that coincides with a strobe show the hold, close-on-entry and priority rules.

// File: rtl/lock_pkg.sv
package lock_pkg;

  localparam int CMP_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ONE  = 2'b01,
    ST_TWO  = 2'b10,
    ST_OPEN = 2'b11
  } lock_state_e;

  // True when a strobed entry equals a wanted direction/value pair.
  function automatic logic entry_equals(input logic got_dir, input logic [CMP_W-1:0] got_val,
                                        input logic want_dir, input logic [CMP_W-1:0] want_val);
    return (got_dir == want_dir) && (got_val == want_val);
  endfunction

  // Successor of a state along the combination path.
  function automatic lock_state_e advance(input lock_state_e s);
    case (s)
      ST_IDLE: return ST_ONE;
      ST_ONE:  return ST_TWO;
      ST_TWO:  return ST_OPEN;
      default: return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/lock_step_match.sv
module lock_step_match
  import lock_pkg::*;
#(
  parameter int DIAL_W  = 5,
  parameter bit A_DIR   = 1'b0,
  parameter int A_VAL   = 13,
  parameter bit B_DIR   = 1'b1,
  parameter int B_VAL   = 22,
  parameter bit C_DIR   = 1'b0,
  parameter int C_VAL   = 3
) (
  input  lock_state_e        state_q,
  input  logic               entry_dir,
  input  logic [DIAL_W-1:0]  entry_val,
  output logic               step_hit,
  output logic               first_hit
);
  logic [CMP_W-1:0] val_ext;
  assign val_ext = CMP_W'(entry_val);

  assign first_hit = entry_equals(entry_dir, val_ext, A_DIR, CMP_W'(A_VAL));

  always_comb begin
    case (state_q)
      ST_IDLE: step_hit = first_hit;
      ST_ONE:  step_hit = entry_equals(entry_dir, val_ext, B_DIR, CMP_W'(B_VAL));
      ST_TWO:  step_hit = entry_equals(entry_dir, val_ext, C_DIR, CMP_W'(C_VAL));
      default: step_hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/lock_next_state.sv
module lock_next_state
  import lock_pkg::*;
(
  input  lock_state_e state_q,
  input  logic        entry_valid,
  input  logic        relock,
  input  logic        step_hit,
  input  logic        first_hit,
  output lock_state_e state_d,
  output logic        ev_advance,
  output logic        ev_restart,
  output logic        ev_miss,
  output logic        ev_close
);
  logic take_entry;
  assign take_entry = entry_valid && !relock;
  assign ev_close   = relock || (take_entry && (state_q == ST_OPEN));
  assign ev_advance = take_entry && (state_q != ST_OPEN) && step_hit;
  assign ev_restart = take_entry && (state_q != ST_OPEN) && !step_hit && first_hit;
  assign ev_miss    = take_entry && (state_q != ST_OPEN) && !step_hit && !first_hit;

  always_comb begin
    state_d = state_q;
    if (ev_close)        state_d = ST_IDLE;
    else if (ev_advance) state_d = advance(state_q);
    else if (ev_restart) state_d = ST_ONE;
    else if (ev_miss)    state_d = ST_IDLE;
  end
endmodule

// File: rtl/lock_state_reg.sv
module lock_state_reg
  import lock_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  lock_state_e state_d,
  output lock_state_e state_q
);
  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/combo_lock.sv
module combo_lock
  import lock_pkg::*;
#(
  parameter int DIAL_W = 5,
  parameter bit A_DIR  = 1'b0,
  parameter int A_VAL  = 13,
  parameter bit B_DIR  = 1'b1,
  parameter int B_VAL  = 22,
  parameter bit C_DIR  = 1'b0,
  parameter int C_VAL  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              entry_valid,
  input  logic              entry_dir,
  input  logic [DIAL_W-1:0] entry_val,
  input  logic              relock,
  output logic              unlocked,
  output logic [1:0]        state_code
);
  lock_state_e state_q, state_d;
  logic step_hit, first_hit;
  logic ev_advance, ev_restart, ev_miss, ev_close;

  lock_step_match #(
    .DIAL_W(DIAL_W), .A_DIR(A_DIR), .A_VAL(A_VAL), .B_DIR(B_DIR),
    .B_VAL(B_VAL), .C_DIR(C_DIR), .C_VAL(C_VAL)
  ) u_match (
    .state_q(state_q), .entry_dir(entry_dir), .entry_val(entry_val),
    .step_hit(step_hit), .first_hit(first_hit)
  );

  lock_next_state u_next (
    .state_q(state_q), .entry_valid(entry_valid), .relock(relock),
    .step_hit(step_hit), .first_hit(first_hit), .state_d(state_d),
    .ev_advance(ev_advance), .ev_restart(ev_restart), .ev_miss(ev_miss),
    .ev_close(ev_close)
  );

  lock_state_reg u_reg (
    .clk(clk), .rst(rst), .state_d(state_d), .state_q(state_q)
  );

  assign state_code = state_q;
  assign unlocked   = (state_q == ST_OPEN);

  AST_HOLD_IDLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (!entry_valid && !relock) |=> $stable(state_code)); // R4
  AST_RELOCK_WINS: assert property (@(posedge clk) disable iff (rst)
    relock |=> (state_code == 2'b00)); // R9
  AST_OPEN_FROM_TWO: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> ($past(state_code) == 2'b10 && $past(entry_valid))); // R3
  AST_MISS_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    ev_miss |=> (state_code == 2'b00)); // R5
  AST_RESTART_FIRST: assert property (@(posedge clk) disable iff (rst)
    ev_restart |=> (state_code == 2'b01)); // R5
  AST_OPEN_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (entry_valid && unlocked) |=> !unlocked); // R8
  AST_ADVANCE_STEP: assert property (@(posedge clk) disable iff (rst)
    ev_advance |=> (state_code == $past(state_code) + 2'd1)); // R3
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_advance, ev_restart, ev_miss, ev_close})); // R5
endmodule

// File: tb/tb_combo_lock.sv
`timescale 1ns/1ps
module tb_combo_lock;
  logic clk = 1'b0;
  logic rst, entry_valid, entry_dir, relock;
  logic [4:0] entry_val;
  logic unlocked;
  logic [1:0] state_code;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam bit R = 1'b0;
  localparam bit L = 1'b1;

  always #10 clk = ~clk;

  combo_lock dut (
    .clk(clk), .rst(rst), .entry_valid(entry_valid), .entry_dir(entry_dir),
    .entry_val(entry_val), .relock(relock), .unlocked(unlocked), .state_code(state_code)
  );

  task automatic expect_state(input string tag, input logic [1:0] exp);
    checks++;
    if (state_code !== exp || unlocked !== (exp == 2'b11)) begin
      failures++;
      $display("FAIL %s: state=%b unlocked=%b expected state=%b unlocked=%b",
               tag, state_code, unlocked, exp, exp == 2'b11);
    end
  endtask

  // One strobe; returns at the negedge after the capturing edge.
  task automatic dial(input logic d, input logic [4:0] v);
    @(negedge clk);
    entry_valid = 1'b1; entry_dir = d; entry_val = v;
    @(negedge clk);
    entry_valid = 1'b0; entry_dir = 1'b0; entry_val = '0;
  endtask

  task automatic pulse_relock(input logic with_strobe);
    @(negedge clk);
    relock = 1'b1;
    entry_valid = with_strobe; entry_dir = R; entry_val = 5'd13;
    @(negedge clk);
    relock = 1'b0; entry_valid = 1'b0; entry_val = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    expect_state("R1 reset idle", 2'b00);
  endtask

  task automatic t_correct();
    do_reset();
    dial(R, 5'd13); expect_state("R2 R3 first step code", 2'b01);
    dial(L, 5'd22); expect_state("R2 R3 second step code", 2'b10);
    dial(R, 5'd3);  expect_state("R3 R7 open", 2'b11);
    repeat (3) @(negedge clk);
    expect_state("R4 open holds with no strobe", 2'b11);
    dial(R, 5'd3);  expect_state("R8 strobe while open closes", 2'b00);
  endtask

  task automatic t_wrong_order();
    do_reset();
    dial(L, 5'd22); expect_state("R10 L22 first stays idle", 2'b00);
    dial(R, 5'd13); expect_state("R10 then R13", 2'b01);
    dial(R, 5'd3);  expect_state("R10 R3 before L22 misses", 2'b00);
    dial(R, 5'd3); dial(R, 5'd13); dial(L, 5'd22);
    expect_state("R10 3,13,22 not open", 2'b10);
  endtask

  task automatic t_wrong_dir();
    do_reset();
    dial(L, 5'd13); expect_state("R6 left 13 stays idle", 2'b00);
    dial(R, 5'd13); dial(R, 5'd22);
    expect_state("R6 right 22 misses", 2'b00);
    dial(R, 5'd13); dial(L, 5'd22); dial(L, 5'd3);
    expect_state("R6 left 3 misses", 2'b00);
  endtask

  task automatic t_recovery();
    do_reset();
    dial(R, 5'd13); dial(L, 5'd22);
    dial(R, 5'd13); expect_state("R5 R13 in step two restarts", 2'b01);
    dial(R, 5'd13); expect_state("R5 R13 in step one restarts", 2'b01);
    repeat (4) @(negedge clk);
    expect_state("R4 partial holds", 2'b01);
    dial(L, 5'd22); dial(R, 5'd31);
    expect_state("R5 value 31 misses", 2'b00);
    dial(R, 5'd13); dial(L, 5'd22); dial(R, 5'd3);
    expect_state("R3 open after recovery", 2'b11);
  endtask

  task automatic t_relock();
    do_reset();
    dial(R, 5'd13); dial(L, 5'd22); dial(R, 5'd3);
    pulse_relock(1'b1);
    expect_state("R9 relock beats strobe when open", 2'b00);
    dial(R, 5'd13);
    pulse_relock(1'b1);
    expect_state("R9 relock beats R13 in step one", 2'b00);
    dial(R, 5'd13); dial(L, 5'd22);
    pulse_relock(1'b0);
    expect_state("R9 relock from step two", 2'b00);
    dial(R, 5'd13); dial(L, 5'd22);
    do_reset();
    expect_state("R1 reset mid sequence", 2'b00);
  endtask

  initial begin
    rst = 1'b1; entry_valid = 1'b0; entry_dir = 1'b0; entry_val = '0; relock = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_correct();
    t_wrong_order();
    t_wrong_dir();
    t_recovery();
    t_relock();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule